// File: doc/BRIEF.md
# Banked-Register 8-bit Accumulator Core

This block is a compact 8-bit accumulator processor. Its general registers sit in 256-byte register banks held on chip, and the active bank is picked by a bank-select register. The control registers are shared and appear at indices 0 to 15 of every bank. Because of this, an ordinary register store can move the instruction pointer, switch the active register bank, or retarget the code or data bank.

Each instruction is three bytes long: an opcode, then operand 1, then operand 2. The core fetches them one byte per cycle from a synchronous code memory addressed by {code bank, instruction pointer}. It then spends one cycle executing the instruction. Data memory is a synchronous read/write port addressed by {data bank, operand 1}. A halt instruction parks the core and raises the halt output until reset. The number of physical register banks is a parameter, and the bank-select value is reduced modulo that number.

Top module: `bankacc_core`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the core clears A, B, C, D, F, the mode, the instruction pointer (IP), the link and the scratch registers. Afterwards `halted` is low, `data_we` is low and `code_addr` reads 0x0000, even if the core was halted before.
- R2: The core fetches the three instruction bytes on consecutive cycles from `{C, IP}`, `{C, IP+1}` and `{C, IP+2}`, with the low byte wrapping within the code bank. Every instruction takes 4 cycles, except opcode 0x03, which takes 5.
- R3: The ALU opcodes are 0x05 AND, 0x06 OR, 0x07 XOR and 0x08 ADD. Each one writes `reg[op1] op reg[op2]` (ADD modulo 256) into A.
- R4: After an ALU opcode, F holds: bit0 = result is zero, bit1 = carry out of ADD (0 for the other ALU opcodes), bit2 = result bit 7, bit3 = result has an even number of ones, and bits 7..4 = 0. No other opcode changes F, except a register store to index 4.
- R5: 0x01 loads A from `reg[op1]`, and 0x02 stores A into `reg[op1]`. Indices 0..15 are the shared control file (0 A, 1 B, 2 C, 3 D, 4 F, 5 mode, 6 IP, 7 link, 8..15 scratch). Indices 16..255 address bank `B mod NUM_BANKS`.
- R6: A store to index 1 changes the bank used by all following instructions. Bank selection wraps modulo NUM_BANKS. B reads back through index 1 from any bank.
- R7: A store to index 2 makes the next fetch come from the new code bank at `IP+3`. A store to index 3 moves later data accesses to the new data bank. A store to index 6 makes the next fetch start at the stored value.
- R8: 0x04 drives `data_we` high for exactly its execute cycle, writing A to `{D, op1}`. 0x03 reads `{D, op1}` and loads the returned byte into A one cycle later.
- R9: 0x10, 0x11, 0x12 and 0x13 test F bit0, bit1, bit2 and bit3 respectively. When the bit is set, IP becomes `IP + 3 + signed(op1)` modulo 256. Otherwise IP becomes `IP + 3`.
- R10: 0x20 saves `IP + 3` into the link (index 7) and jumps to `op1`. 0x21 reloads IP from the link.
- R11: Any opcode outside the defined set advances IP by 3 and changes no register or flag.
- R12: 0xFF sets `halted` on the cycle after its execute cycle. It leaves IP on the halt instruction, and from then on `halted`, `code_addr` and a low `data_we` stay fixed until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| code_addr | output | 16 | Code memory byte address {C, IP + byte index} |
| code_rdata | input | 8 | Code byte for the address of the previous cycle |
| data_addr | output | 16 | Data memory address {D, op1} |
| data_wdata | output | 8 | Data memory write byte (always A) |
| data_we | output | 1 | Data memory write strobe |
| data_rdata | input | 8 | Data byte for the address of the previous cycle |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The bench builds the core with NUM_BANKS = 4 and models code and data memory as four 256-byte banks each. With only four physical banks, a bank-select value of 5 must alias bank 1, which puts the wrap of R6 in reach. Four code and data banks are also enough to show a store to C or D moving fetches and data writes out of bank 0. Because registers only get values through data-memory loads, every check feeds constants through data memory and reads results back out through stores to it.

// File: rtl/bankacc_pkg.sv
`timescale 1ns/1ps
// Package: shared opcodes, control-register indices, sequencer phases and
// the flag-building function for the banked accumulator core.
package bankacc_pkg;

    localparam int DW = 8;

    // Opcode values
    localparam logic [7:0] OPC_NOP  = 8'h00;
    localparam logic [7:0] OPC_LDA  = 8'h01;
    localparam logic [7:0] OPC_STA  = 8'h02;
    localparam logic [7:0] OPC_LDM  = 8'h03;
    localparam logic [7:0] OPC_STM  = 8'h04;
    localparam logic [7:0] OPC_AND  = 8'h05;
    localparam logic [7:0] OPC_OR   = 8'h06;
    localparam logic [7:0] OPC_XOR  = 8'h07;
    localparam logic [7:0] OPC_ADD  = 8'h08;
    localparam logic [7:0] OPC_JZ   = 8'h10;
    localparam logic [7:0] OPC_JC   = 8'h11;
    localparam logic [7:0] OPC_JS   = 8'h12;
    localparam logic [7:0] OPC_JP   = 8'h13;
    localparam logic [7:0] OPC_CALL = 8'h20;
    localparam logic [7:0] OPC_RET  = 8'h21;
    localparam logic [7:0] OPC_HALT = 8'hFF;

    // Indices of the shared control registers
    localparam int IDX_A    = 0;
    localparam int IDX_B    = 1;
    localparam int IDX_C    = 2;
    localparam int IDX_D    = 3;
    localparam int IDX_F    = 4;
    localparam int IDX_MODE = 5;
    localparam int IDX_IP   = 6;
    localparam int IDX_LINK = 7;

    // Sequencer phases
    typedef enum logic [2:0] {
        PH_F0  = 3'd0,
        PH_F1  = 3'd1,
        PH_F2  = 3'd2,
        PH_EX  = 3'd3,
        PH_MW  = 3'd4,
        PH_HLT = 3'd5
    } phase_e;

    // Builds the flag byte for an ALU result and carry
    function automatic logic [7:0] make_flags(input logic [7:0] res, input logic cy);
        return {4'b0000, ~^res, res[7], cy, (res == 8'h00)};
    endfunction

    // True when an opcode is one of the two-operand ALU operations
    function automatic logic is_alu(input logic [7:0] opc);
        return (opc == OPC_AND) || (opc == OPC_OR) || (opc == OPC_XOR) || (opc == OPC_ADD);
    endfunction

    // True when an opcode is one of the four conditional jumps
    function automatic logic is_jcc(input logic [7:0] opc);
        return (opc == OPC_JZ) || (opc == OPC_JC) || (opc == OPC_JS) || (opc == OPC_JP);
    endfunction

endpackage

// File: rtl/bankacc_seq.sv
`timescale 1ns/1ps
// Module: bankacc_seq
// Byte sequencer for the three-byte instruction fetch. It walks through the
// phases F0, F1, F2 and EX, adds a wait phase after a data-memory load and
// parks in HLT after a halt. It latches the opcode and operand 1 as they
// return from the synchronous code memory.
// Assumes: code memory returns the byte for the address of the previous
// cycle; operand 2 is used straight from the code port during EX.
module bankacc_seq
    import bankacc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    code_byte,
    output phase_e           phase,
    output logic [DW-1:0]    opcode,
    output logic [DW-1:0]    op1,
    output logic [1:0]       byte_idx
);

    phase_e        phase_q;
    logic [DW-1:0] opcode_q;
    logic [DW-1:0] op1_q;

    // Phase advance and capture of the opcode and operand 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_F0;
            opcode_q <= '0;
            op1_q    <= '0;
        end else begin
            case (phase_q)
                PH_F0: phase_q <= PH_F1;
                PH_F1: begin
                    opcode_q <= code_byte;
                    phase_q  <= PH_F2;
                end
                PH_F2: begin
                    op1_q   <= code_byte;
                    phase_q <= PH_EX;
                end
                PH_EX: begin
                    if (opcode_q == OPC_HALT)
                        phase_q <= PH_HLT;
                    else if (opcode_q == OPC_LDM)
                        phase_q <= PH_MW;
                    else
                        phase_q <= PH_F0;
                end
                PH_MW:   phase_q <= PH_F0;
                PH_HLT:  phase_q <= PH_HLT;
                default: phase_q <= PH_F0;
            endcase
        end
    end

    // Offset of the byte presented to code memory in each phase
    always_comb begin
        case (phase_q)
            PH_F1:   byte_idx = 2'd1;
            PH_F2:   byte_idx = 2'd2;
            default: byte_idx = 2'd0;
        endcase
    end

    assign phase  = phase_q;
    assign opcode = opcode_q;
    assign op1    = op1_q;

endmodule

// File: rtl/bankacc_regfile.sv
`timescale 1ns/1ps
// Module: bankacc_regfile
// Banked register store. Indices below CTRL_DEPTH address one shared control
// file that every bank sees. Higher indices address the bank chosen by the
// bank-select register modulo NUM_BANKS. It has two combinational read
// ports, one general write port, and dedicated write ports for A, F, IP and
// the link. A general write to a control index takes priority over a
// dedicated write in the same cycle.
// Assumes: NUM_BANKS is a power of two and at least 2.
module bankacc_regfile
    import bankacc_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int CTRL_DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    rd0_idx,
    output logic [DW-1:0]    rd0_data,
    input  logic [DW-1:0]    rd1_idx,
    output logic [DW-1:0]    rd1_data,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic             a_we,
    input  logic [DW-1:0]    a_data,
    input  logic             f_we,
    input  logic [DW-1:0]    f_data,
    input  logic             ip_we,
    input  logic [DW-1:0]    ip_data,
    input  logic             link_we,
    input  logic [DW-1:0]    link_data,
    output logic [DW-1:0]    reg_a,
    output logic [DW-1:0]    reg_c,
    output logic [DW-1:0]    reg_d,
    output logic [DW-1:0]    reg_f,
    output logic [DW-1:0]    reg_ip,
    output logic [DW-1:0]    reg_link
);

    localparam int BANK_BITS = $clog2(NUM_BANKS);
    localparam int CTRL_BITS = $clog2(CTRL_DEPTH);
    localparam int BANK_SIZE = 1 << DW;
    localparam int MEM_DEPTH = NUM_BANKS * BANK_SIZE;
    localparam logic [DW-1:0] CTRL_LIMIT = DW'(CTRL_DEPTH);

    logic [DW-1:0] ctrl_q   [CTRL_DEPTH];
    logic [DW-1:0] bank_mem [MEM_DEPTH];
    logic [BANK_BITS-1:0] bank_idx;

    assign bank_idx = ctrl_q[IDX_B][BANK_BITS-1:0];

    // Shared control file: dedicated ports first, general write last
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CTRL_DEPTH; i++) ctrl_q[i] <= '0;
        end else begin
            if (a_we)    ctrl_q[IDX_A]    <= a_data;
            if (f_we)    ctrl_q[IDX_F]    <= f_data;
            if (ip_we)   ctrl_q[IDX_IP]   <= ip_data;
            if (link_we) ctrl_q[IDX_LINK] <= link_data;
            if (wr_en && (wr_idx < CTRL_LIMIT))
                ctrl_q[wr_idx[CTRL_BITS-1:0]] <= wr_data;
        end
    end

    // Banked storage above the control window (not reset)
    always_ff @(posedge clk) begin
        if (wr_en && (wr_idx >= CTRL_LIMIT))
            bank_mem[{bank_idx, wr_idx}] <= wr_data;
    end

    // Read port 0: control window or active bank
    always_comb begin
        if (rd0_idx < CTRL_LIMIT) rd0_data = ctrl_q[rd0_idx[CTRL_BITS-1:0]];
        else                      rd0_data = bank_mem[{bank_idx, rd0_idx}];
    end

    // Read port 1: control window or active bank
    always_comb begin
        if (rd1_idx < CTRL_LIMIT) rd1_data = ctrl_q[rd1_idx[CTRL_BITS-1:0]];
        else                      rd1_data = bank_mem[{bank_idx, rd1_idx}];
    end

    assign reg_a    = ctrl_q[IDX_A];
    assign reg_c    = ctrl_q[IDX_C];
    assign reg_d    = ctrl_q[IDX_D];
    assign reg_f    = ctrl_q[IDX_F];
    assign reg_ip   = ctrl_q[IDX_IP];
    assign reg_link = ctrl_q[IDX_LINK];

endmodule

// File: rtl/bankacc_alu.sv
`timescale 1ns/1ps
// Module: bankacc_alu
// Combinational two-operand ALU. It computes AND, OR, XOR or ADD, along with
// the flag byte for the result.
// Assumes: the caller only uses the outputs for ALU opcodes.
module bankacc_alu
    import bankacc_pkg::*;
(
    input  logic [DW-1:0] opcode,
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    output logic [DW-1:0] result,
    output logic [DW-1:0] flags
);

    logic [DW:0] sum;
    logic        carry;

    assign sum = {1'b0, lhs} + {1'b0, rhs};

    // Operation select and carry generation
    always_comb begin
        carry = 1'b0;
        case (opcode)
            OPC_AND: result = lhs & rhs;
            OPC_OR:  result = lhs | rhs;
            OPC_XOR: result = lhs ^ rhs;
            OPC_ADD: begin
                result = sum[DW-1:0];
                carry  = sum[DW];
            end
            default: result = '0;
        endcase
    end

    assign flags = make_flags(result, carry);

endmodule

// File: rtl/bankacc_core.sv
`timescale 1ns/1ps
// Module: bankacc_core (top)
// 8-bit accumulator core with banked registers. The sequencer fetches three
// code bytes, then this module decodes the opcode and, in the execute phase,
// drives the register file, the ALU and the data-memory port.
// Assumes: code and data memories are synchronous, each with one cycle of
// read latency; stores always write A.
module bankacc_core
    import bankacc_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] code_addr,
    input  logic [7:0]  code_rdata,
    output logic [15:0] data_addr,
    output logic [7:0]  data_wdata,
    output logic        data_we,
    input  logic [7:0]  data_rdata,
    output logic        halted
);

    localparam logic [DW-1:0] INSN_BYTES = DW'(3);

    phase_e        phase;
    logic [DW-1:0] opcode, op1;
    logic [1:0]    byte_idx;
    logic          in_ex, in_mw, in_f0, in_f1;

    logic [DW-1:0] rd0_data, rd1_data;
    logic          wr_en, a_we, f_we, ip_we, link_we;
    logic [DW-1:0] a_data, ip_data;
    logic [DW-1:0] reg_a, reg_c, reg_d, reg_f, reg_ip, reg_link;
    logic [DW-1:0] alu_res, alu_flags;
    logic [DW-1:0] ip_seq;
    logic          jump_taken;

    bankacc_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_byte (code_rdata),
        .phase     (phase),
        .opcode    (opcode),
        .op1       (op1),
        .byte_idx  (byte_idx)
    );

    bankacc_regfile #(
        .NUM_BANKS  (NUM_BANKS),
        .CTRL_DEPTH (16)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd0_idx   (op1),
        .rd0_data  (rd0_data),
        .rd1_idx   (code_rdata),
        .rd1_data  (rd1_data),
        .wr_en     (wr_en),
        .wr_idx    (op1),
        .wr_data   (reg_a),
        .a_we      (a_we),
        .a_data    (a_data),
        .f_we      (f_we),
        .f_data    (alu_flags),
        .ip_we     (ip_we),
        .ip_data   (ip_data),
        .link_we   (link_we),
        .link_data (ip_seq),
        .reg_a     (reg_a),
        .reg_c     (reg_c),
        .reg_d     (reg_d),
        .reg_f     (reg_f),
        .reg_ip    (reg_ip),
        .reg_link  (reg_link)
    );

    bankacc_alu u_alu (
        .opcode (opcode),
        .lhs    (rd0_data),
        .rhs    (rd1_data),
        .result (alu_res),
        .flags  (alu_flags)
    );

    assign in_ex  = (phase == PH_EX);
    assign in_mw  = (phase == PH_MW);
    assign in_f0  = (phase == PH_F0);
    assign in_f1  = (phase == PH_F1);
    assign ip_seq = reg_ip + INSN_BYTES;

    // Jump condition: opcode low bits pick the flag bit to test
    assign jump_taken = reg_f[opcode[2:0]];

    // Execute-phase decode of register-file controls and the next IP
    always_comb begin
        wr_en   = 1'b0;
        a_we    = 1'b0;
        a_data  = rd0_data;
        f_we    = 1'b0;
        link_we = 1'b0;
        ip_we   = in_ex && (opcode != OPC_HALT);
        ip_data = ip_seq;
        if (in_mw) begin
            a_we   = 1'b1;
            a_data = data_rdata;
        end else if (in_ex) begin
            if (opcode == OPC_LDA) begin
                a_we = 1'b1;
            end else if (opcode == OPC_STA) begin
                wr_en = 1'b1;
            end else if (is_alu(opcode)) begin
                a_we   = 1'b1;
                a_data = alu_res;
                f_we   = 1'b1;
            end else if (is_jcc(opcode)) begin
                if (jump_taken) ip_data = ip_seq + op1;
            end else if (opcode == OPC_CALL) begin
                link_we = 1'b1;
                ip_data = op1;
            end else if (opcode == OPC_RET) begin
                ip_data = reg_link;
            end
        end
    end

    assign code_addr  = {reg_c, reg_ip + {6'b0, byte_idx}};
    assign data_addr  = {reg_d, op1};
    assign data_wdata = reg_a;
    assign data_we    = in_ex && (opcode == OPC_STM);
    assign halted     = (phase == PH_HLT);

endmodule

// File: rtl/bankacc_core_chk.sv
`timescale 1ns/1ps
// Module: bankacc_core_chk
// Property checker bound to bankacc_core. It observes the fetch stepping,
// the write strobe and the halt behaviour.
module bankacc_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] code_addr,
    input logic        data_we,
    input logic        halted,
    input logic        in_f0,
    input logic        in_f1
);

    // R2: consecutive fetch bytes step the low address byte, same code bank
    assert_fetch_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_f0 || in_f1) |=> (code_addr[15:8] == $past(code_addr[15:8]) &&
                              code_addr[7:0] == $past(code_addr[7:0]) + 8'd1));

    // R8: a data write lasts exactly one cycle
    assert_we_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        data_we |=> !data_we);

    // R12: halt persists until reset
    assert_halt_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R12: fetch address frozen while halted
    assert_halt_addr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(code_addr));

    // R12: no data write while halted
    assert_halt_no_we_R12: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !data_we);

endmodule

bind bankacc_core bankacc_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .code_addr (code_addr),
    .data_we   (data_we),
    .halted    (halted),
    .in_f0     (in_f0),
    .in_f1     (in_f1)
);

// File: tb/bankacc_core_tb.sv
`timescale 1ns/1ps
// Bench for bankacc_core: models code and data memory, loads a small program
// per test, runs it to HALT and checks results through data memory.
module bankacc_core_tb;

    localparam int MEMSZ = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] code_addr, data_addr;
    logic [7:0]  code_rdata, data_wdata, data_rdata;
    logic        data_we, halted;

    logic [7:0]  cmem [MEMSZ];
    logic [7:0]  dmem [MEMSZ];
    logic        tb_clr = 1'b0;
    logic        tb_we = 1'b0;
    logic [9:0]  tb_addr = '0;
    logic [7:0]  tb_wdata = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc_total = 0;

    always #2.5 clk = ~clk;

    bankacc_core #(.NUM_BANKS(4)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_addr  (code_addr),
        .code_rdata (code_rdata),
        .data_addr  (data_addr),
        .data_wdata (data_wdata),
        .data_we    (data_we),
        .data_rdata (data_rdata),
        .halted     (halted)
    );

    // Synchronous code and data memory models
    always @(posedge clk) begin
        code_rdata <= cmem[code_addr[9:0]];
        if (tb_clr) begin
            for (int i = 0; i < MEMSZ; i++) dmem[i] <= 8'h00;
        end else if (tb_we) begin
            dmem[tb_addr] <= tb_wdata;
        end else if (data_we) begin
            dmem[data_addr[9:0]] <= data_wdata;
        end
        data_rdata <= dmem[data_addr[9:0]];
    end

    // Watchdog
    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected < 150000)", cyc_total);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Hold reset, clear memories, fill code with HALT
    task automatic prep();
        @(negedge clk);
        rst_n  = 1'b0;
        tb_clr = 1'b1;
        @(negedge clk);
        tb_clr = 1'b0;
        for (int i = 0; i < MEMSZ; i++) cmem[i] = 8'hFF;
    endtask

    task automatic emit(input int addr, input logic [7:0] opc, input logic [7:0] a, input logic [7:0] b);
        cmem[addr % MEMSZ]       = opc;
        cmem[(addr + 1) % MEMSZ] = a;
        cmem[(addr + 2) % MEMSZ] = b;
    endtask

    task automatic poke(input int addr, input logic [7:0] val);
        tb_addr  = 10'(addr);
        tb_wdata = val;
        tb_we    = 1'b1;
        @(negedge clk);
        tb_we    = 1'b0;
    endtask

    // Release reset and run until halted; returns cycle count
    task automatic run(output int cyc);
        cyc = 0;
        rst_n = 1'b1;
        while (!halted && cyc < 3000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        if (!halted) check("R12 program timeout", 0, 1);
    endtask

    // ALU vectors: {opcode, lhs, rhs, expected A, expected F}
    localparam logic [39:0] ALU_VEC [9] = '{
        {8'h08, 8'h7F, 8'h01, 8'h80, 8'h04},
        {8'h08, 8'hFF, 8'h01, 8'h00, 8'h0B},
        {8'h05, 8'hF0, 8'h0F, 8'h00, 8'h09},
        {8'h06, 8'h0F, 8'h30, 8'h3F, 8'h08},
        {8'h07, 8'hAA, 8'hFF, 8'h55, 8'h08},
        {8'h08, 8'h03, 8'h04, 8'h07, 8'h00},
        {8'h07, 8'h81, 8'h00, 8'h81, 8'h0C},
        {8'h05, 8'hC3, 8'h81, 8'h81, 8'h0C},
        {8'h08, 8'h80, 8'h80, 8'h00, 8'h0B}
    };

    initial begin
        int cyc;
        logic [7:0] mask;

        // R3 / R4 / R5 / R8: ALU table walk
        for (int i = 0; i < 9; i++) begin
            prep();
            poke(0, ALU_VEC[i][31:24]);
            poke(1, ALU_VEC[i][23:16]);
            emit(0,  8'h03, 8'h00, 8'h00);
            emit(3,  8'h02, 8'h20, 8'h00);
            emit(6,  8'h03, 8'h01, 8'h00);
            emit(9,  8'h02, 8'h21, 8'h00);
            emit(12, ALU_VEC[i][39:32], 8'h20, 8'h21);
            emit(15, 8'h04, 8'h10, 8'h00);
            emit(18, 8'h01, 8'h04, 8'h00);
            emit(21, 8'h04, 8'h11, 8'h00);
            run(cyc);
            check($sformatf("R3 alu vector %0d result", i), int'(dmem[16]), int'(ALU_VEC[i][15:8]));
            check($sformatf("R4 alu vector %0d flags", i), int'(dmem[17]), int'(ALU_VEC[i][7:0]));
        end

        // R9: each conditional jump, taken and not taken
        for (int j = 0; j < 4; j++) begin
            for (int t = 0; t < 2; t++) begin
                mask = (t == 1) ? 8'(1 << j) : (8'h0F & ~8'(1 << j));
                prep();
                poke(0, mask);
                poke(16, 8'hEE);
                emit(0, 8'h03, 8'h00, 8'h00);
                emit(3, 8'h02, 8'h04, 8'h00);
                emit(6, 8'(8'h10 + j), 8'h03, 8'h00);
                emit(9, 8'h04, 8'h10, 8'h00);
                run(cyc);
                check($sformatf("R9 jump 0x1%0d taken=%0d", j, t), int'(dmem[16]),
                      (t == 1) ? 32'hEE : int'(mask));
            end
        end

        // R9: backward jump wraps modulo 256 within the code bank
        prep();
        poke(0, 8'h01);
        poke(16, 8'hEE);
        emit(0, 8'h03, 8'h00, 8'h00);
        emit(3, 8'h02, 8'h04, 8'h00);
        emit(6, 8'h10, 8'hF4, 8'h00);
        emit(9, 8'h04, 8'h10, 8'h00);
        run(cyc);
        check("R9 wrap halt address", int'(code_addr), 32'h00FD);
        check("R9 wrap skipped store", int'(dmem[16]), 32'hEE);
        // R12: halt held and fetch address frozen
        repeat (20) @(negedge clk);
        check("R12 halted held", int'(halted), 1);
        check("R12 address frozen", int'(code_addr), 32'h00FD);

        // R10: call and return with link readable at index 7
        prep();
        poke(0, 8'h5A);
        emit(0,    8'h20, 8'h30, 8'h00);
        emit(3,    8'h04, 8'h11, 8'h00);
        emit(8'h30, 8'h03, 8'h00, 8'h00);
        emit(8'h33, 8'h04, 8'h10, 8'h00);
        emit(8'h36, 8'h01, 8'h07, 8'h00);
        emit(8'h39, 8'h04, 8'h12, 8'h00);
        emit(8'h3C, 8'h21, 8'h00, 8'h00);
        run(cyc);
        check("R10 subroutine ran", int'(dmem[16]), 32'h5A);
        check("R10 link value", int'(dmem[18]), 3);
        check("R10 returned to caller", int'(dmem[17]), 3);

        // R5 / R6: bank switching, modulo wrap, shared B
        prep();
        poke(0, 8'h11); poke(1, 8'h01); poke(2, 8'h22); poke(3, 8'h00); poke(4, 8'h05);
        emit(0,  8'h03, 8'h00, 8'h00);
        emit(3,  8'h02, 8'h40, 8'h00);
        emit(6,  8'h03, 8'h01, 8'h00);
        emit(9,  8'h02, 8'h01, 8'h00);
        emit(12, 8'h03, 8'h02, 8'h00);
        emit(15, 8'h02, 8'h40, 8'h00);
        emit(18, 8'h03, 8'h03, 8'h00);
        emit(21, 8'h02, 8'h01, 8'h00);
        emit(24, 8'h01, 8'h40, 8'h00);
        emit(27, 8'h04, 8'h10, 8'h00);
        emit(30, 8'h03, 8'h04, 8'h00);
        emit(33, 8'h02, 8'h01, 8'h00);
        emit(36, 8'h01, 8'h40, 8'h00);
        emit(39, 8'h04, 8'h11, 8'h00);
        emit(42, 8'h01, 8'h01, 8'h00);
        emit(45, 8'h04, 8'h12, 8'h00);
        run(cyc);
        check("R5 bank 0 register kept", int'(dmem[16]), 32'h11);
        check("R6 bank 5 aliases bank 1", int'(dmem[17]), 32'h22);
        check("R6 B readable in bank", int'(dmem[18]), 5);

        // R7: store to C and D retargets code and data banks
        prep();
        poke(0, 8'h01);
        emit(0,      8'h03, 8'h00, 8'h00);
        emit(3,      8'h02, 8'h02, 8'h00);
        emit(16'h106, 8'h02, 8'h03, 8'h00);
        emit(16'h109, 8'h04, 8'h10, 8'h00);
        run(cyc);
        check("R7 data bank 1 written", int'(dmem[16'h110]), 1);
        check("R7 data bank 0 untouched", int'(dmem[16]), 0);
        check("R7 code bank halt address", int'(code_addr), 32'h010C);

        // R1: reset from a halted state
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset code_addr", int'(code_addr), 0);
        check("R1 reset halted", int'(halted), 0);
        check("R1 reset data_we", int'(data_we), 0);

        // R7: store to IP redirects fetch
        prep();
        poke(0, 8'h20);
        emit(0, 8'h03, 8'h00, 8'h00);
        emit(3, 8'h02, 8'h06, 8'h00);
        emit(6, 8'h04, 8'h10, 8'h00);
        run(cyc);
        check("R7 IP store target", int'(code_addr), 32'h0020);
        check("R7 IP store skipped", int'(dmem[16]), 0);

        // R11: undefined opcode changes nothing
        prep();
        poke(16, 8'hEE);
        poke(17, 8'hEE);
        emit(0,  8'h09, 8'h04, 8'h04);
        emit(3,  8'h01, 8'h04, 8'h00);
        emit(6,  8'h04, 8'h10, 8'h00);
        emit(9,  8'h01, 8'h00, 8'h00);
        emit(12, 8'h04, 8'h11, 8'h00);
        run(cyc);
        check("R11 flags unchanged", int'(dmem[16]), 0);
        check("R11 A unchanged", int'(dmem[17]), 0);

        // R2: cycle counts
        prep();
        emit(0, 8'h00, 8'h00, 8'h00);
        emit(3, 8'h00, 8'h00, 8'h00);
        run(cyc);
        check("R2 three instructions take 12 cycles", cyc, 12);
        prep();
        emit(0, 8'h03, 8'h00, 8'h00);
        run(cyc);
        check("R2 load plus halt take 9 cycles", cyc, 9);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule